// File: doc/BRIEF.md
# Trace Waypoint Interface Checker

This block watches the per-cycle waypoint bus that runs from a processor core to its program-flow trace unit. It checks every field of that bus and flags any cycle that breaks an interface rule. It never drives the bus. Each waypoint carries a type, an exception code, link and taken flags, a trace-prohibited flag, a last-executed PC, a target PC with its instruction-set state bits, a commit count and a flush strobe.

Each rule has its own sticky error bit, which a synchronous clear input resets. A one-cycle pulse marks every violating cycle. A pending counter follows how many waypoints have been issued but not yet committed. Some rules look only at the current cycle: type codes, field cross-constraints and alignment. Other rules need state carried between cycles: debug entry and exit must pair, only one valid cycle may carry the trace-prohibited flag, and commits must never outrun the waypoints issued.

Top module: `wpt_protocol_checker`

## Requirements
- R1: A valid waypoint whose type is 3'b110 or 3'b111 sets error bit 0. The legal types are 000 direct branch, 001 indirect branch, 010 exception, 011 barrier, 100 debug entry and 101 debug exit.
- R2: A valid waypoint with the link flag set sets error bit 1 unless its type is 000 or 001.
- R3: A valid waypoint of type 010 through 101 whose taken flag is low sets error bit 2. Branch types may have the taken flag low.
- R4: A valid waypoint sets error bit 3 in either of two cases: its target PC has bit 1 set while the target T bit is low, or its target PC has bit 0 set while the target J bit is low.
- R5: A valid waypoint that carries the trace-prohibited flag, or whose type is 100 or 101, sets error bit 4 when its target PC is not zero.
- R6: Error bit 5 is set in two cases: a valid debug entry (100) arrives while an earlier entry is still open, or a valid debug exit (101) arrives with no entry open. A valid debug exit closes the open entry.
- R7: After one valid waypoint with the trace-prohibited flag, every further valid waypoint sets error bit 6. This lasts until a cycle with the waypoint enable input low, which lets trace resume.
- R8: A valid exception waypoint (010) whose exception code is outside the set {0001, 0010, 0100, 0101, 1000, 1001, 1010, 1011, 1100, 1110, 1111} sets error bit 7.
- R9: A valid exception waypoint with exception code 1000 (reset) and a last-executed PC that is not zero sets error bit 8.
- R10: The pending count goes up by one on each valid cycle and down by the commit count (0 to 3), with the same-cycle valid added first. A valid cycle may therefore commit its own waypoint. If the commit count exceeds the count plus the valid, error bit 9 is set and the count becomes 0. A flush sets the count to 0 and suppresses this check in its cycle. In the default build the count saturates at 63.
- R11: An error bit is set on the clock edge that ends its violating cycle and stays set until a cycle with the clear input high. If a new violation and a clear fall in the same cycle, the new violation's bit is still set.
- R12: The error pulse output is high for exactly the one cycle after each violating cycle and low after a clean cycle.
- R13: After reset all error bits are 0, the pulse is low, the pending count is 0, no debug entry is open and no prohibited waypoint is recorded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| clr_i | input | 1 | Clears all sticky error bits |
| wpt_en_i | input | 1 | Waypoint enable; low lets trace resume after a prohibited waypoint |
| wpt_valid_i | input | 1 | Waypoint valid this cycle |
| wpt_commit_i | input | 2 | Number of waypoints committed this cycle |
| wpt_flush_i | input | 1 | Discards all uncommitted waypoints |
| wpt_type_i | input | 3 | Waypoint type code |
| wpt_exc_i | input | 4 | Exception code |
| wpt_link_i | input | 1 | Branch writes the link register |
| wpt_taken_i | input | 1 | Waypoint passed its condition |
| wpt_prohib_i | input | 1 | Target lies in a trace-prohibited region |
| wpt_pc_i | input | 32 | Last executed address |
| wpt_tgt_pc_i | input | 32 | Target address |
| wpt_tgt_t_i | input | 1 | Target T state bit |
| wpt_tgt_j_i | input | 1 | Target J state bit |
| err_sticky_o | output | 10 | Sticky error bits, one per rule |
| err_pulse_o | output | 1 | One-cycle pulse after any violating cycle |
| pending_o | output | 6 | Count of uncommitted waypoints |

## Verification
Two pairs of functions can land in the same cycle. The first pair is a software clear of the sticky bits and a fresh violation. The bench sets one bit, then drives a clear together with a reserved-type waypoint. It expects exactly the new bit to remain and the pulse to be high. The second pair is a valid waypoint and a commit, or a commit and a flush. The bench drives these with a pending count of one and of zero. It judges the outcome from the pending count and from whether the underflow bit appears.

// File: rtl/wpt_chk_pkg.sv
package wpt_chk_pkg;

   localparam int N_RULES      = 10;
   localparam int IDX_TYPE     = 0;
   localparam int IDX_LINK     = 1;
   localparam int IDX_TAKEN    = 2;
   localparam int IDX_ALIGN    = 3;
   localparam int IDX_TGT_ZERO = 4;
   localparam int IDX_DBG      = 5;
   localparam int IDX_PROHIB   = 6;
   localparam int IDX_EXC      = 7;
   localparam int IDX_RST_PC   = 8;
   localparam int IDX_UNDER    = 9;

   typedef enum logic [2:0] {
      WT_DIRECT    = 3'b000,
      WT_INDIRECT  = 3'b001,
      WT_EXCEPT    = 3'b010,
      WT_BARRIER   = 3'b011,
      WT_DBG_ENTRY = 3'b100,
      WT_DBG_EXIT  = 3'b101,
      WT_RSVD6     = 3'b110,
      WT_RSVD7     = 3'b111
   } wpt_type_e;

   localparam logic [3:0] EXC_RESET = 4'b1000;

   function automatic logic exc_code_legal(input logic [3:0] code);
      logic ok;
      case (code)
         4'b0001, 4'b0010, 4'b0100, 4'b0101,
         4'b1000, 4'b1001, 4'b1010, 4'b1011,
         4'b1100, 4'b1110, 4'b1111: ok = 1'b1;
         default:                   ok = 1'b0;
      endcase
      return ok;
   endfunction

endpackage

// File: rtl/wpt_field_rules.sv
module wpt_field_rules
   import wpt_chk_pkg::*;
#(
   parameter int PC_W = 32
) (
   input  logic                valid_i,
   input  logic [2:0]          type_i,
   input  logic [3:0]          exc_i,
   input  logic                link_i,
   input  logic                taken_i,
   input  logic                prohib_i,
   input  logic [PC_W-1:0]     pc_i,
   input  logic [PC_W-1:0]     tgt_pc_i,
   input  logic                tgt_t_i,
   input  logic                tgt_j_i,
   output logic [N_RULES-1:0]  viol_o
);

   wpt_type_e wt;
   logic      is_branch;
   logic      is_debug;

   assign wt        = wpt_type_e'(type_i);
   assign is_branch = (wt == WT_DIRECT) || (wt == WT_INDIRECT);
   assign is_debug  = (wt == WT_DBG_ENTRY) || (wt == WT_DBG_EXIT);

   always_comb begin
      viol_o = '0;
      if (valid_i) begin
         viol_o[IDX_TYPE]     = (wt == WT_RSVD6) || (wt == WT_RSVD7);
         viol_o[IDX_LINK]     = link_i && !is_branch;
         viol_o[IDX_TAKEN]    = !taken_i && (wt inside {WT_EXCEPT, WT_BARRIER,
                                                        WT_DBG_ENTRY, WT_DBG_EXIT});
         viol_o[IDX_ALIGN]    = (!tgt_t_i && tgt_pc_i[1]) || (!tgt_j_i && tgt_pc_i[0]);
         viol_o[IDX_TGT_ZERO] = (prohib_i || is_debug) && (tgt_pc_i != '0);
         viol_o[IDX_EXC]      = (wt == WT_EXCEPT) && !exc_code_legal(exc_i);
         viol_o[IDX_RST_PC]   = (wt == WT_EXCEPT) && (exc_i == EXC_RESET) && (pc_i != '0);
      end
   end

endmodule

// File: rtl/wpt_seq_tracker.sv
module wpt_seq_tracker
   import wpt_chk_pkg::*;
(
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               en_i,
   input  logic               valid_i,
   input  logic [2:0]         type_i,
   input  logic               prohib_i,
   output logic [N_RULES-1:0] viol_o
);

   wpt_type_e wt;
   logic      dbg_open_q;
   logic      prohib_seen_q;

   assign wt = wpt_type_e'(type_i);

   always_comb begin
      viol_o = '0;
      if (valid_i) begin
         viol_o[IDX_DBG]    = ((wt == WT_DBG_ENTRY) && dbg_open_q) ||
                              ((wt == WT_DBG_EXIT) && !dbg_open_q);
         viol_o[IDX_PROHIB] = prohib_seen_q;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         dbg_open_q <= 1'b0;
      end else if (valid_i && (wt == WT_DBG_ENTRY)) begin
         dbg_open_q <= 1'b1;
      end else if (valid_i && (wt == WT_DBG_EXIT)) begin
         dbg_open_q <= 1'b0;
      end
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         prohib_seen_q <= 1'b0;
      end else if (!en_i) begin
         prohib_seen_q <= 1'b0;
      end else if (valid_i && prohib_i) begin
         prohib_seen_q <= 1'b1;
      end
   end

endmodule

// File: rtl/wpt_pend_counter.sv
module wpt_pend_counter
   import wpt_chk_pkg::*;
#(
   parameter int CNT_W    = 2,
   parameter int PEND_W   = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               valid_i,
   input  logic [CNT_W-1:0]   commit_i,
   input  logic               flush_i,
   output logic [PEND_W-1:0]  pending_o,
   output logic [N_RULES-1:0] viol_o
);

   localparam int          SUM_W    = PEND_W + 1;
   localparam logic [PEND_W-1:0] PEND_MAX = {PEND_W{1'b1}};

   logic [PEND_W-1:0] pend_q;
   logic [PEND_W-1:0] pend_d;
   logic [SUM_W-1:0]  up;
   logic [SUM_W-1:0]  cm;
   logic [SUM_W-1:0]  diff;
   logic              under;
   logic [PEND_W-1:0] capped;

   assign up    = {1'b0, pend_q} + {{PEND_W{1'b0}}, valid_i};
   assign cm    = SUM_W'(commit_i);
   assign under = cm > up;
   assign diff  = up - cm;

   generate
      if (SATURATE) begin : g_sat
         assign capped = diff[PEND_W] ? PEND_MAX : diff[PEND_W-1:0];
      end else begin : g_wrap
         logic unused_top;
         assign unused_top = diff[PEND_W];
         assign capped     = diff[PEND_W-1:0];
      end
   endgenerate

   always_comb begin
      if (flush_i || under) pend_d = '0;
      else                  pend_d = capped;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) pend_q <= '0;
      else         pend_q <= pend_d;
   end

   always_comb begin
      viol_o            = '0;
      viol_o[IDX_UNDER] = under && !flush_i;
   end

   assign pending_o = pend_q;

endmodule

// File: rtl/wpt_err_bank.sv
module wpt_err_bank #(
   parameter int N = 10
) (
   input  logic         clk_i,
   input  logic         rst_ni,
   input  logic         clr_i,
   input  logic [N-1:0] viol_i,
   output logic [N-1:0] sticky_o,
   output logic         pulse_o
);

   generate
      for (genvar g = 0; g < N; g++) begin : g_bit
         logic bit_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni)        bit_q <= 1'b0;
            else if (viol_i[g]) bit_q <= 1'b1;
            else if (clr_i)     bit_q <= 1'b0;
         end
         assign sticky_o[g] = bit_q;
      end
   endgenerate

   logic pulse_q;
   always_ff @(posedge clk_i) begin
      if (!rst_ni) pulse_q <= 1'b0;
      else         pulse_q <= |viol_i;
   end
   assign pulse_o = pulse_q;

endmodule

// File: rtl/wpt_protocol_checker.sv
module wpt_protocol_checker
   import wpt_chk_pkg::*;
#(
   parameter int PC_W     = 32,
   parameter int CNT_W    = 2,
   parameter int PEND_W   = 6,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk_i,
   input  logic               rst_ni,
   input  logic               clr_i,
   input  logic               wpt_en_i,
   input  logic               wpt_valid_i,
   input  logic [CNT_W-1:0]   wpt_commit_i,
   input  logic               wpt_flush_i,
   input  logic [2:0]         wpt_type_i,
   input  logic [3:0]         wpt_exc_i,
   input  logic               wpt_link_i,
   input  logic               wpt_taken_i,
   input  logic               wpt_prohib_i,
   input  logic [PC_W-1:0]    wpt_pc_i,
   input  logic [PC_W-1:0]    wpt_tgt_pc_i,
   input  logic               wpt_tgt_t_i,
   input  logic               wpt_tgt_j_i,
   output logic [N_RULES-1:0] err_sticky_o,
   output logic               err_pulse_o,
   output logic [PEND_W-1:0]  pending_o
);

   generate
      if (PC_W < 2) begin : g_bad_pc_w
         $error("PC_W must be at least 2");
      end
      if (PEND_W < CNT_W) begin : g_bad_pend_w
         $error("PEND_W must be at least CNT_W");
      end
   endgenerate

   logic [N_RULES-1:0] field_viol;
   logic [N_RULES-1:0] seq_viol;
   logic [N_RULES-1:0] pend_viol;
   logic [N_RULES-1:0] all_viol;

   wpt_field_rules #(.PC_W(PC_W)) u_field (
      .valid_i  (wpt_valid_i),
      .type_i   (wpt_type_i),
      .exc_i    (wpt_exc_i),
      .link_i   (wpt_link_i),
      .taken_i  (wpt_taken_i),
      .prohib_i (wpt_prohib_i),
      .pc_i     (wpt_pc_i),
      .tgt_pc_i (wpt_tgt_pc_i),
      .tgt_t_i  (wpt_tgt_t_i),
      .tgt_j_i  (wpt_tgt_j_i),
      .viol_o   (field_viol)
   );

   wpt_seq_tracker u_seq (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .en_i     (wpt_en_i),
      .valid_i  (wpt_valid_i),
      .type_i   (wpt_type_i),
      .prohib_i (wpt_prohib_i),
      .viol_o   (seq_viol)
   );

   wpt_pend_counter #(
      .CNT_W    (CNT_W),
      .PEND_W   (PEND_W),
      .SATURATE (SATURATE)
   ) u_pend (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .valid_i   (wpt_valid_i),
      .commit_i  (wpt_commit_i),
      .flush_i   (wpt_flush_i),
      .pending_o (pending_o),
      .viol_o    (pend_viol)
   );

   assign all_viol = field_viol | seq_viol | pend_viol;

   wpt_err_bank #(.N(N_RULES)) u_err (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .clr_i    (clr_i),
      .viol_i   (all_viol),
      .sticky_o (err_sticky_o),
      .pulse_o  (err_pulse_o)
   );

endmodule

// File: rtl/wpt_protocol_checker_sva.sv
module wpt_protocol_checker_sva
   import wpt_chk_pkg::*;
#(
   parameter int PC_W   = 32,
   parameter int CNT_W  = 2,
   parameter int PEND_W = 6
) (
   input logic               clk_i,
   input logic               rst_ni,
   input logic               clr_i,
   input logic               wpt_valid_i,
   input logic [CNT_W-1:0]   wpt_commit_i,
   input logic               wpt_flush_i,
   input logic [2:0]         wpt_type_i,
   input logic [PC_W-1:0]    wpt_tgt_pc_i,
   input logic [N_RULES-1:0] err_sticky_o,
   input logic               err_pulse_o,
   input logic [PEND_W-1:0]  pending_o
);

   // R1: reserved type code always lands in bit 0
   a_r1_reserved_type: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wpt_valid_i && (wpt_type_i[2:1] == 2'b11)) |=> err_sticky_o[IDX_TYPE]);

   // R5: debug waypoints with a non-zero target
   a_r5_debug_tgt_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wpt_valid_i && (wpt_type_i[2:1] == 2'b10) && (wpt_tgt_pc_i != '0))
      |=> err_sticky_o[IDX_TGT_ZERO]);

   // R10: flush empties the pending count
   a_r10_flush_empties: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wpt_flush_i |=> (pending_o == '0));

   // R11: a clear in a cycle that cannot violate empties every bit
   a_r11_clear_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i && !wpt_valid_i && (wpt_commit_i == '0)) |=> ((err_sticky_o == '0) && !err_pulse_o));

   // R12: any newly set sticky bit comes with the pulse
   a_r12_pulse_on_new: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((err_sticky_o & ~$past(err_sticky_o)) != '0) |-> err_pulse_o);

endmodule

bind wpt_protocol_checker wpt_protocol_checker_sva #(
   .PC_W   (PC_W),
   .CNT_W  (CNT_W),
   .PEND_W (PEND_W)
) u_sva (
   .clk_i        (clk_i),
   .rst_ni       (rst_ni),
   .clr_i        (clr_i),
   .wpt_valid_i  (wpt_valid_i),
   .wpt_commit_i (wpt_commit_i),
   .wpt_flush_i  (wpt_flush_i),
   .wpt_type_i   (wpt_type_i),
   .wpt_tgt_pc_i (wpt_tgt_pc_i),
   .err_sticky_o (err_sticky_o),
   .err_pulse_o  (err_pulse_o),
   .pending_o    (pending_o)
);

// File: tb/wpt_protocol_checker_tb.sv
module wpt_protocol_checker_tb;

   logic        clk_i = 1'b0;
   logic        rst_ni;
   logic        clr_i;
   logic        wpt_en_i;
   logic        wpt_valid_i;
   logic [1:0]  wpt_commit_i;
   logic        wpt_flush_i;
   logic [2:0]  wpt_type_i;
   logic [3:0]  wpt_exc_i;
   logic        wpt_link_i;
   logic        wpt_taken_i;
   logic        wpt_prohib_i;
   logic [31:0] wpt_pc_i;
   logic [31:0] wpt_tgt_pc_i;
   logic        wpt_tgt_t_i;
   logic        wpt_tgt_j_i;
   logic [9:0]  err_sticky_o;
   logic        err_pulse_o;
   logic [5:0]  pending_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk_i = ~clk_i;

   wpt_protocol_checker u_dut (.*);

   task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic go_idle();
      clr_i = 0; wpt_en_i = 1; wpt_valid_i = 0; wpt_commit_i = 0; wpt_flush_i = 0;
      wpt_type_i = 3'b001; wpt_exc_i = 4'b1111; wpt_link_i = 0; wpt_taken_i = 1;
      wpt_prohib_i = 0; wpt_pc_i = 0; wpt_tgt_pc_i = 0; wpt_tgt_t_i = 0; wpt_tgt_j_i = 0;
   endtask

   // legal indirect branch that commits itself
   task automatic wp_default();
      go_idle();
      wpt_valid_i = 1; wpt_commit_i = 1;
   endtask

   task automatic step();
      @(posedge clk_i); #1;
      go_idle();
   endtask

   task automatic clear_all();
      go_idle(); clr_i = 1; wpt_flush_i = 1;
      step();
   endtask

   task automatic expect_err(input logic [9:0] mask, input string req);
      chk({22'd0, err_sticky_o}, {22'd0, mask}, req);
      chk({31'd0, err_pulse_o}, {31'd0, (mask != 0)}, req);
      clear_all();
   endtask

   task automatic t_reset();
      chk({22'd0, err_sticky_o}, 0, "R13 sticky");
      chk({31'd0, err_pulse_o}, 0, "R13 pulse");
      chk({26'd0, pending_o}, 0, "R13 pending");
   endtask

   task automatic t_legal();
      wp_default(); wpt_type_i = 3'b000; wpt_taken_i = 0; wpt_link_i = 1; step();
      expect_err(0, "R3 R2 branch not taken with link");
      wp_default(); wpt_type_i = 3'b011; step();
      expect_err(0, "R3 barrier taken");
      wp_default(); wpt_type_i = 3'b010; wpt_exc_i = 4'b1110; wpt_pc_i = 32'h100; step();
      expect_err(0, "R8 legal irq code");
   endtask

   task automatic t_type();
      wp_default(); wpt_type_i = 3'b110; step();
      chk({22'd0, err_sticky_o}, 10'h001, "R1 type 110");
      chk({31'd0, err_pulse_o}, 1, "R12 pulse high");
      step();
      chk({31'd0, err_pulse_o}, 0, "R12 pulse low after clean");
      chk({22'd0, err_sticky_o}, 10'h001, "R11 sticky holds");
      clear_all();
      wp_default(); wpt_type_i = 3'b111; step();
      expect_err(10'h001, "R1 type 111");
   endtask

   task automatic t_fields();
      wp_default(); wpt_type_i = 3'b010; wpt_link_i = 1; step();
      expect_err(10'h002, "R2 link on exception");
      wp_default(); wpt_type_i = 3'b011; wpt_taken_i = 0; step();
      expect_err(10'h004, "R3 barrier not taken");
      wp_default(); wpt_tgt_pc_i = 32'h2; step();
      expect_err(10'h008, "R4 bit1 with T low");
      wp_default(); wpt_tgt_pc_i = 32'h1; wpt_tgt_t_i = 1; step();
      expect_err(10'h008, "R4 bit0 with J low");
      wp_default(); wpt_tgt_pc_i = 32'h3; wpt_tgt_t_i = 1; wpt_tgt_j_i = 1; step();
      expect_err(0, "R4 aligned with T and J");
      wp_default(); wpt_prohib_i = 1; wpt_tgt_pc_i = 32'h40; step();
      expect_err(10'h010, "R5 prohibited non-zero target");
      go_idle(); wpt_en_i = 0; step();   // resume trace after that
   endtask

   task automatic t_debug();
      wp_default(); wpt_type_i = 3'b101; step();
      expect_err(10'h020, "R6 exit without entry");
      wp_default(); wpt_type_i = 3'b100; wpt_tgt_pc_i = 32'h8; step();
      expect_err(10'h010, "R5 debug entry target non-zero");
      wp_default(); wpt_type_i = 3'b100; step();
      expect_err(10'h020, "R6 second entry");
      wp_default(); wpt_type_i = 3'b101; step();
      expect_err(0, "R6 exit closes entry");
      wp_default(); wpt_type_i = 3'b100; step();
      wp_default(); wpt_type_i = 3'b101; step();
      expect_err(0, "R6 clean pair");
   endtask

   task automatic t_prohib();
      wp_default(); wpt_prohib_i = 1; step();
      chk({22'd0, err_sticky_o}, 0, "R7 first prohibited waypoint");
      wp_default(); step();
      expect_err(10'h040, "R7 waypoint after prohibited");
      go_idle(); wpt_en_i = 0; step();
      wp_default(); step();
      expect_err(0, "R7 resumed after enable low");
   endtask

   task automatic t_exc();
      wp_default(); wpt_type_i = 3'b010; wpt_exc_i = 4'b0011; step();
      expect_err(10'h080, "R8 code 0011");
      wp_default(); wpt_type_i = 3'b010; wpt_exc_i = 4'b1101; step();
      expect_err(10'h080, "R8 code 1101");
      wp_default(); wpt_type_i = 3'b010; wpt_exc_i = 4'b1000; wpt_pc_i = 32'h4; step();
      expect_err(10'h100, "R9 reset with pc");
      wp_default(); wpt_type_i = 3'b010; wpt_exc_i = 4'b1000; step();
      expect_err(0, "R9 reset pc zero");
   endtask

   task automatic t_pend();
      for (int i = 0; i < 3; i++) begin
         wp_default(); wpt_commit_i = 0; step();
      end
      chk({26'd0, pending_o}, 3, "R10 three issued");
      wp_default(); wpt_commit_i = 3; step();
      chk({26'd0, pending_o}, 1, "R10 valid plus commit 3");
      chk({22'd0, err_sticky_o}, 0, "R10 no underflow");
      go_idle(); wpt_commit_i = 2; step();
      chk({26'd0, pending_o}, 0, "R10 underflow clamps");
      expect_err(10'h200, "R10 underflow bit");
      wp_default(); step();
      chk({26'd0, pending_o}, 0, "R10 self commit from empty");
      chk({22'd0, err_sticky_o}, 0, "R10 self commit no error");
      wp_default(); wpt_commit_i = 0; step();
      go_idle(); wpt_flush_i = 1; wpt_commit_i = 3; step();
      chk({26'd0, pending_o}, 0, "R10 flush with commit");
      expect_err(0, "R10 flush suppresses underflow");
      for (int i = 0; i < 70; i++) begin
         wp_default(); wpt_commit_i = 0; step();
      end
      chk({26'd0, pending_o}, 63, "R10 saturates");
      expect_err(0, "R10 saturation clean");
   endtask

   task automatic t_clear_race();
      wp_default(); wpt_type_i = 3'b011; wpt_taken_i = 0; step();
      chk({22'd0, err_sticky_o}, 10'h004, "R11 before clear");
      wp_default(); wpt_type_i = 3'b110; clr_i = 1; step();
      chk({22'd0, err_sticky_o}, 10'h001, "R11 set wins over clear");
      chk({31'd0, err_pulse_o}, 1, "R12 pulse on race");
      clear_all();
      chk({22'd0, err_sticky_o}, 0, "R11 clear empties");
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      go_idle();
      rst_ni = 0;
      repeat (3) @(posedge clk_i);
      #1 rst_ni = 1;
      t_reset();
      t_legal();
      t_type();
      t_fields();
      t_debug();
      t_prohib();
      t_exc();
      t_pend();
      t_clear_race();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule